// File: doc/BRIEF.md
# Boot-Overlay Memory Address Decoder

This block sits between an 8-bit processor bus with 16-bit addresses and three targets: a 4 KB boot EPROM, a general RAM and a small system control register. For every byte access it decides which target answers and works out the EPROM offset. The EPROM is read through a combinational port. RAM is read combinationally and written on the clock edge.

Three address windows can be mapped to the EPROM. The monitor window at the top of the address space is always ROM. A startup window at the bottom of memory and a diagnostic window just below the monitor are each switched between ROM and RAM by one bit of the control register. Both bits are clear after reset, so both overlays start as ROM. A write that decodes to ROM never reaches RAM. Instead, a one-cycle violation pulse is raised, and the target address and the program counter of the offending access are captured.

A word access takes two cycles. Each half goes through the same decode and write protection as a single byte. The two bytes are ordered little-endian, and a word that starts at the last address wraps its upper byte to address zero.

Top module: `boot_overlay_decoder`

## Requirements
- R1: An address of 0xF800 or above always decodes to the EPROM at offset (address − 0xF000), whatever the control register holds.
- R2: While control bit 2 is 0, an address below 0x1000 decodes to the EPROM at offset equal to the address.
- R3: While control bit 4 is 0, an address from 0xE800 to 0xEFFF decodes to the EPROM at offset (address − 0xE800).
- R4: Every address not claimed by an active ROM window is served by RAM for reads and writes. Windows are tested in the order monitor, startup, diagnostic, then RAM. A byte access completes in the cycle it is requested, with read data on rdata_o[7:0] and 0 on rdata_o[15:8].
- R5: A write that decodes to ROM does not assert ram_we_o, and the RAM contents stay unchanged.
- R6: In the cycle after a blocked write, viol_o is 1 for one cycle, viol_addr_o holds the byte address and viol_pc_o holds pc_i of that access. A read, or a write to RAM, leaves viol_o at 0 in the following cycle.
- R7: The control register is 8 bits wide and resets to 0x00. A write with ctrl_we_i loads all 8 bits, and the new value is visible on ctrl_o from the next cycle. Setting bit 2 or bit 4 hands the matching window to RAM.
- R8: A word read (word_i=1) is accepted when ready_o is 1. It reads the address in the request cycle and address+1 in the next cycle. done_o is 1 in that second cycle only, and rdata_o then holds {byte at address+1, byte at address}.
- R9: A word write stores wdata_i[7:0] at the address in the request cycle and wdata_i[15:8] at address+1 in the next cycle. Each byte is decoded, protected and reported on its own, and both bytes carry the pc_i of the request.
- R10: A word access that starts at 0xFFFF places its second byte at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, sampled when ready_o is 1 |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address of the access |
| wdata_i | input | 16 | Write data; a byte access uses bits 7:0 |
| pc_i | input | 16 | Program counter of the requesting instruction |
| ready_o | output | 1 | Block can accept a new request |
| done_o | output | 1 | Access completes this cycle |
| rdata_o | output | 16 | Read data, valid while done_o is 1 |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write value |
| ctrl_o | output | 8 | Current control register value |
| rom_en_o | output | 1 | EPROM read enable |
| rom_addr_o | output | 12 | EPROM byte offset |
| rom_rdata_i | input | 8 | EPROM read data (combinational) |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 16 | Bus byte address of the current access |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data (combinational) |
| viol_o | output | 1 | One-cycle pulse after a blocked write |
| viol_addr_o | output | 16 | Address of the last blocked write |
| viol_pc_o | output | 16 | Program counter of the last blocked write |

## Verification
The hardest case to reach is a word write whose two halves decode differently. Examples are a word at 0x0FFF with the startup overlay active, or a word at 0xFFFF with the overlay released: one byte must be dropped and reported while the other lands in RAM. Random addresses alone almost never produce this, so the stimulus picks addresses within a few bytes of every window edge, including the wrap point. It also flips the two overlay bits between accesses, so that the same addresses are visited under each mapping. After an overlay is released, reading back through RAM shows whether a blocked write leaked into memory.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {SEQ_IDLE, SEQ_HI} seq_state_e;

  typedef struct packed {
    logic              vld;
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
    logic [ADDR_W-1:0] pc;
  } bus_acc_t;
endpackage

// File: rtl/ovl_decode.sv
module ovl_decode
  import ovl_pkg::*;
#(
  parameter int unsigned       ROM_AW     = 12,
  parameter logic [ADDR_W-1:0] MON_BASE   = 16'hF800,
  parameter logic [ADDR_W-1:0] MON_OFS    = 16'hF000,
  parameter logic [ADDR_W-1:0] BOOT_LIMIT = 16'h1000,
  parameter logic [ADDR_W-1:0] DIAG_BASE  = 16'hE800,
  parameter logic [ADDR_W-1:0] DIAG_LIMIT = 16'hF000,
  parameter int unsigned       BOOT_BIT   = 2,
  parameter int unsigned       DIAG_BIT   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] ctrl_i,
  output logic              rom_sel_o,
  output logic [ROM_AW-1:0] rom_off_o
);
  // priority: monitor, startup, diagnostic, RAM
  always_comb begin
    rom_sel_o = 1'b0;
    rom_off_o = '0;
    if (addr_i >= MON_BASE) begin
      rom_sel_o = 1'b1;
      rom_off_o = ROM_AW'(addr_i - MON_OFS);
    end else if (addr_i < BOOT_LIMIT && !ctrl_i[BOOT_BIT]) begin
      rom_sel_o = 1'b1;
      rom_off_o = ROM_AW'(addr_i);
    end else if (addr_i >= DIAG_BASE && addr_i < DIAG_LIMIT && !ctrl_i[DIAG_BIT]) begin
      rom_sel_o = 1'b1;
      rom_off_o = ROM_AW'(addr_i - DIAG_BASE);
    end
  end
endmodule

// File: rtl/ovl_word_seq.sv
module ovl_word_seq
  import ovl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                word_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [BYTE_W-1:0]   byte_rdata_i,
  output bus_acc_t            acc_o,
  output logic                ready_o,
  output logic                done_o,
  output logic [2*BYTE_W-1:0] rdata_o
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] hi_addr_q;
  logic [BYTE_W-1:0] hi_data_q;
  logic [BYTE_W-1:0] lo_q;
  logic              we_q;
  logic [ADDR_W-1:0] pc_q;

  always_comb begin
    acc_o   = '0;
    done_o  = 1'b0;
    rdata_o = '0;
    ready_o = (state_q == SEQ_IDLE);
    if (state_q == SEQ_IDLE) begin
      if (req_i) begin
        acc_o   = '{vld: 1'b1, we: we_i, addr: addr_i, data: wdata_i[BYTE_W-1:0], pc: pc_i};
        done_o  = !word_i;
        rdata_o = {{BYTE_W{1'b0}}, byte_rdata_i};
      end
    end else begin
      acc_o   = '{vld: 1'b1, we: we_q, addr: hi_addr_q, data: hi_data_q, pc: pc_q};
      done_o  = 1'b1;
      rdata_o = {byte_rdata_i, lo_q};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEQ_IDLE;
      hi_addr_q <= '0;
      hi_data_q <= '0;
      lo_q      <= '0;
      we_q      <= 1'b0;
      pc_q      <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (req_i && word_i) begin
        state_q   <= SEQ_HI;
        hi_addr_q <= addr_i + 1'b1;  // wraps at top of space
        hi_data_q <= wdata_i[2*BYTE_W-1:BYTE_W];
        lo_q      <= byte_rdata_i;
        we_q      <= we_i;
        pc_q      <= pc_i;
      end
    end else begin
      state_q <= SEQ_IDLE;
    end
  end

  p_word_second_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_HI) |-> (acc_o.addr == $past(addr_i) + 16'd1));

  p_word_two_cycles_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_HI) |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/ovl_viol.sv
module ovl_viol
  import ovl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              viol_o,
  output logic [ADDR_W-1:0] viol_addr_o,
  output logic [ADDR_W-1:0] viol_pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_addr_o <= '0;
      viol_pc_o   <= '0;
    end else begin
      viol_o <= blk_i;
      if (blk_i) begin
        viol_addr_o <= addr_i;
        viol_pc_o   <= pc_i;
      end
    end
  end

  p_capture_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_i |=> ($stable(viol_addr_o) && $stable(viol_pc_o)));
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import ovl_pkg::*;
#(
  parameter int unsigned       ROM_AW     = 12,
  parameter logic [ADDR_W-1:0] MON_BASE   = 16'hF800,
  parameter logic [ADDR_W-1:0] MON_OFS    = 16'hF000,
  parameter logic [ADDR_W-1:0] BOOT_LIMIT = 16'h1000,
  parameter logic [ADDR_W-1:0] DIAG_BASE  = 16'hE800,
  parameter logic [ADDR_W-1:0] DIAG_LIMIT = 16'hF000,
  parameter int unsigned       BOOT_BIT   = 2,
  parameter int unsigned       DIAG_BIT   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          word_i,
  input  logic          we_i,
  input  logic [15:0]   addr_i,
  input  logic [15:0]   wdata_i,
  input  logic [15:0]   pc_i,
  output logic          ready_o,
  output logic          done_o,
  output logic [15:0]   rdata_o,
  input  logic          ctrl_we_i,
  input  logic [7:0]    ctrl_wdata_i,
  output logic [7:0]    ctrl_o,
  output logic          rom_en_o,
  output logic [ROM_AW-1:0] rom_addr_o,
  input  logic [7:0]    rom_rdata_i,
  output logic          ram_en_o,
  output logic          ram_we_o,
  output logic [15:0]   ram_addr_o,
  output logic [7:0]    ram_wdata_o,
  input  logic [7:0]    ram_rdata_i,
  output logic          viol_o,
  output logic [15:0]   viol_addr_o,
  output logic [15:0]   viol_pc_o
);
  logic [BYTE_W-1:0] ctrl_q;
  bus_acc_t          acc;
  logic              rom_sel;
  logic [ROM_AW-1:0] rom_off;
  logic [BYTE_W-1:0] byte_rd;
  logic              blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
  end
  assign ctrl_o = ctrl_q;

  ovl_word_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .word_i       (word_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .pc_i         (pc_i),
    .byte_rdata_i (byte_rd),
    .acc_o        (acc),
    .ready_o      (ready_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o)
  );

  ovl_decode #(
    .ROM_AW     (ROM_AW),
    .MON_BASE   (MON_BASE),
    .MON_OFS    (MON_OFS),
    .BOOT_LIMIT (BOOT_LIMIT),
    .DIAG_BASE  (DIAG_BASE),
    .DIAG_LIMIT (DIAG_LIMIT),
    .BOOT_BIT   (BOOT_BIT),
    .DIAG_BIT   (DIAG_BIT)
  ) u_dec (
    .addr_i    (acc.addr),
    .ctrl_i    (ctrl_q),
    .rom_sel_o (rom_sel),
    .rom_off_o (rom_off)
  );

  assign byte_rd     = rom_sel ? rom_rdata_i : ram_rdata_i;
  assign rom_en_o    = acc.vld && rom_sel && !acc.we;
  assign rom_addr_o  = rom_off;
  assign ram_en_o    = acc.vld && !rom_sel;
  assign ram_we_o    = ram_en_o && acc.we;
  assign ram_addr_o  = acc.addr;
  assign ram_wdata_o = acc.data;
  assign blk         = acc.vld && acc.we && rom_sel;

  ovl_viol u_viol (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blk_i       (blk),
    .addr_i      (acc.addr),
    .pc_i        (acc.pc),
    .viol_o      (viol_o),
    .viol_addr_o (viol_addr_o),
    .viol_pc_o   (viol_pc_o)
  );

  p_monitor_rom_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc.vld && acc.addr >= MON_BASE) |-> !ram_en_o);

  p_boot_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc.vld && !acc.we && acc.addr < BOOT_LIMIT && !ctrl_q[BOOT_BIT])
      |-> (rom_en_o && rom_addr_o == acc.addr[ROM_AW-1:0]));

  p_target_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_en_o && ram_en_o));

  p_ram_write_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !viol_o);

  p_rom_read_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_en_o |=> !viol_o);
endmodule

// File: tb/boot_overlay_decoder_tb.sv
module boot_overlay_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, word = 1'b0, we = 1'b0;
  logic [15:0] addr = '0, wdata = '0, pc = '0;
  logic        ready, done;
  logic [15:0] rdata;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0, ctrl;
  logic        rom_en;
  logic [11:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic        ram_en, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, ram_rdata;
  logic        viol;
  logic [15:0] viol_addr, viol_pc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] ctrl_m = '0;

  // memory models: entry = {valid, addr[15:12], data}
  logic [12:0] ram_mem [4096];
  logic [12:0] shadow  [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_overlay_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .word_i(word), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .pc_i(pc), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl),
    .rom_en_o(rom_en), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata), .viol_o(viol),
    .viol_addr_o(viol_addr), .viol_pc_o(viol_pc)
  );

  function automatic logic [7:0] rom_fn(logic [11:0] i);
    return i[7:0] ^ {i[11:8], ~i[11:8]};
  endfunction

  function automatic logic [7:0] fill(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [7:0] ram_rd(logic [15:0] a);
    logic [12:0] e = ram_mem[a[11:0]];
    return (e[12] && e[11:8] == a[15:12]) ? e[7:0] : fill(a);
  endfunction

  function automatic logic [7:0] sh_rd(logic [15:0] a);
    logic [12:0] e = shadow[a[11:0]];
    return (e[12] && e[11:8] == a[15:12]) ? e[7:0] : fill(a);
  endfunction

  // {is_rom, offset}
  function automatic logic [12:0] map(logic [15:0] a, logic [7:0] c);
    if (a >= 16'hF800) return {1'b1, 12'(a - 16'hF000)};
    if (a < 16'h1000 && !c[2]) return {1'b1, a[11:0]};
    if (a >= 16'hE800 && a < 16'hF000 && !c[4]) return {1'b1, 12'(a - 16'hE800)};
    return {1'b0, 12'h000};
  endfunction

  function automatic string tag(logic [15:0] a, logic [7:0] c);
    logic [12:0] m = map(a, c);
    if (!m[12]) return "R4";
    if (a >= 16'hF800) return "R1";
    if (a < 16'h1000) return "R2";
    return "R3";
  endfunction

  function automatic logic [7:0] exp_rd(logic [15:0] a);
    logic [12:0] m = map(a, ctrl_m);
    return m[12] ? rom_fn(m[11:0]) : sh_rd(a);
  endfunction

  always_comb rom_rdata = rom_fn(rom_addr);
  always_comb ram_rdata = ram_rd(ram_addr);
  always @(posedge clk) if (ram_en && ram_we) ram_mem[ram_addr[11:0]] <= {1'b1, ram_addr[15:12], ram_wdata};

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, expv);
    end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (!map(a, ctrl_m)[12]) shadow[a[11:0]] = {1'b1, a[15:12], d};
  endtask

  task automatic check_viol(input logic [15:0] a, input bit wr, input logic [15:0] p, input string t);
    bit ev = wr && map(a, ctrl_m)[12];
    chk(viol == ev, {t, " R6 viol"}, 32'(viol), 32'(ev));
    if (ev) begin
      chk(viol_addr == a, {t, " R6 viol_addr"}, 32'(viol_addr), 32'(a));
      chk(viol_pc == p, {t, " R6 viol_pc"}, 32'(viol_pc), 32'(p));
    end
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0; ctrl_m = v; #1;
    chk(ctrl == v, "R7 ctrl load", 32'(ctrl), 32'(v));
  endtask

  task automatic do_byte(input bit w, input logic [15:0] a, input logic [7:0] d, input logic [15:0] p);
    logic [7:0] e;
    @(negedge clk); req = 1'b1; word = 1'b0; we = w; addr = a; wdata = {8'h00, d}; pc = p;
    e = exp_rd(a); #1;
    chk(done == 1'b1, "R4 byte done", 32'(done), 32'd1);
    if (!w) chk(rdata == {8'h00, e}, {tag(a, ctrl_m), " byte read"}, 32'(rdata), 32'({8'h00, e}));
    @(negedge clk); req = 1'b0; #1;
    check_viol(a, w, p, w ? "R5 byte write" : "byte read");
    if (w) model_write(a, d);
  endtask

  task automatic do_word(input bit w, input logic [15:0] a, input logic [15:0] d, input logic [15:0] p);
    logic [15:0] ah = a + 16'd1;
    logic [15:0] e;
    string t = (a == 16'hFFFF) ? "R10" : (w ? "R9" : "R8");
    @(negedge clk); req = 1'b1; word = 1'b1; we = w; addr = a; wdata = d; pc = p;
    e = {exp_rd(ah), exp_rd(a)}; #1;
    chk(done == 1'b0, {t, " word first cycle not done"}, 32'(done), 32'd0);
    @(negedge clk); req = 1'b0; #1;
    chk(done == 1'b1 && ready == 1'b0, {t, " word second cycle done"}, 32'({ready, done}), 32'b01);
    if (!w) chk(rdata == e, {t, " word read"}, 32'(rdata), 32'(e));
    check_viol(a, w, p, {t, " low byte"});
    if (w) model_write(a, d[7:0]);
    @(negedge clk); #1;
    check_viol(ah, w, p, {t, " high byte"});
    if (w) model_write(ah, d[15:8]);
    chk(ready == 1'b1, {t, " R8 ready after word"}, 32'(ready), 32'd1);
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] bases [8] = '{16'h0000, 16'h0FF8, 16'h1000, 16'hE7F8,
                               16'hE800, 16'hEFF8, 16'hF7F8, 16'hFFF8};
    if ($urandom % 5 == 0) return 16'($urandom);
    return bases[$urandom % 8] + 16'($urandom % 16);
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) begin ram_mem[i] = '0; shadow[i] = '0; end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ctrl == 8'h00, "R7 reset ctrl", 32'(ctrl), 32'h0);
    chk(viol == 1'b0, "R6 reset viol", 32'(viol), 32'h0);
    chk(ready == 1'b1, "R8 reset ready", 32'(ready), 32'h1);

    // directed: window edges with both overlays active
    do_byte(0, 16'hF800, 0, 16'h0100);   // R1 offset 0x800
    do_byte(0, 16'hFFFF, 0, 16'h0101);   // R1
    do_byte(0, 16'hF7FF, 0, 16'h0102);   // R4
    do_byte(0, 16'h0000, 0, 16'h0103);   // R2
    do_byte(0, 16'h0FFF, 0, 16'h0104);   // R2
    do_byte(0, 16'h1000, 0, 16'h0105);   // R4
    do_byte(0, 16'hE7FF, 0, 16'h0106);   // R4
    do_byte(0, 16'hE800, 0, 16'h0107);   // R3
    do_byte(0, 16'hEFFF, 0, 16'h0108);   // R3
    do_byte(0, 16'hF000, 0, 16'h0109);   // R4
    // R5: blocked write then read back once released
    do_byte(1, 16'h0010, 8'hAA, 16'h0200);
    do_byte(1, 16'hE810, 8'hBB, 16'h0201);
    do_byte(1, 16'h2010, 8'hCC, 16'h0202);
    do_byte(0, 16'h2010, 0, 16'h0203);
    // R9: word straddling startup edge, low byte blocked
    do_word(1, 16'h0FFF, 16'h5A69, 16'h0300);
    // R10: word read wrapping into startup ROM
    do_word(0, 16'hFFFF, 16'h0000, 16'h0301);
    set_ctrl(8'h14);                     // R7 release both windows
    do_byte(0, 16'h0010, 0, 16'h0400);   // R5 RAM untouched
    do_byte(0, 16'hE810, 0, 16'h0401);   // R5 RAM untouched
    do_byte(0, 16'h1000, 0, 16'h0402);   // R9 high byte landed
    // R10: word write wrapping, high byte to RAM at 0x0000
    do_word(1, 16'hFFFF, 16'h3C7E, 16'h0500);
    do_word(0, 16'hFFFF, 16'h0000, 16'h0501);
    set_ctrl(8'hFF);
    do_byte(1, 16'hF900, 8'h11, 16'h0600); // R1 still protected
    do_byte(0, 16'hF900, 0, 16'h0601);
    set_ctrl(8'h10);                       // R7 only diag released
    do_byte(0, 16'hE900, 0, 16'h0602);
    do_byte(0, 16'h0900, 0, 16'h0603);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int unsigned op = $urandom % 20;
      logic [15:0] a = pick_addr();
      logic [15:0] p = 16'($urandom);
      if (op < 2)       set_ctrl(8'($urandom) & 8'h14 | 8'($urandom) & 8'hEB);
      else if (op < 8)  do_byte(0, a, 0, p);
      else if (op < 12) do_byte(1, a, 8'($urandom), p);
      else if (op < 16) do_word(0, a, 0, p);
      else              do_word(1, a, 16'($urandom), p);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule